// File: doc/BRIEF.md
# Affine ReLU Accelerator with Register-Mapped Control

This block is a small compute accelerator that a host processor drives over an AXI4-Lite slave port. The host loads three signed 32-bit operands into read/write registers, then writes a one to a start bit. The accelerator evaluates max(0, a*x + b) over a fixed number of clock cycles. It places the value in a read-only result register and raises a done flag. The host polls that flag to learn that the result is ready.

Inside the block, a bus port module turns AXI4-Lite channel handshakes into single-cycle register write and read strobes. A register file decodes addresses, applies the access mode of each register and sequences start and done. A compute core forms the product, adds the bias, clamps negative values and signals completion after a parameterised latency.

Top module: `affine_relu_accel`

## Requirements
- R1: The control word at byte offset 0x00 is write-one-to-set: a write with strobe bit 0 set and data bit 0 equal to 1 launches a computation. A write with data bit 0 equal to 0 launches nothing and leaves the done flag and the result unchanged.
- R2: The done flag is bit 0 of offset 0x04 and cannot be written from the bus. It is cleared in the cycle a launch is accepted and reads 0 until the computation completes.
- R3: Operands x (0x08), a (0x0C) and b (0x10) are signed 32-bit read/write registers. Each byte lane `i` of a write updates bits [8i+7:8i] only when `s_wstrb[i]` is 1.
- R4: The result y at 0x14 is read-only and equals max(0, low 32 bits of a*x + b), with both the product and the sum taken as two's-complement signed values.
- R5: Done rises exactly once per accepted launch, `LATENCY` + 2 cycles after the launch pulse. The result register is written in that same cycle. A start written while a computation is in progress or finishing is ignored.
- R6: Writes to read-only offsets (0x04, 0x14), to unmapped offsets or to addresses with nonzero bits [1:0] are answered with OKAY (00) and change nothing. Reads of such unmapped or misaligned addresses return 0 with OKAY.
- R7: The start bit clears one cycle after it is set, so reading offset 0x00 while idle returns 0.
- R8: After reset, all registers read 0, and `s_bvalid` and `s_rvalid` are 0. Once raised, `s_bvalid` and `s_rvalid` stay high with unchanged read data until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address (byte address) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address (byte address) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |

## Verification
The assertions assume that the host follows AXI4-Lite rules. Each valid is held with stable address and data until its ready is seen, and responses are eventually accepted. Under those rules the launch, done and result relations inside the block hold. The bench always raises the address and data valids of a write together, holds them until both readies are high, then waits for the response. It issues one transaction at a time, so it never breaks these rules. The operand sweep covers sign combinations and the extreme values, including products that overflow 32 bits. Directed sequences place a second start inside the compute window and write to every read-only and unmapped location.

// File: rtl/relu_accel_pkg.sv
package relu_accel_pkg;

    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    // Merge the enabled byte lanes of a new word into a stored word.
    function automatic logic [DATA_W-1:0] merge_lanes(
        input logic [DATA_W-1:0] cur,
        input logic [DATA_W-1:0] nxt,
        input logic [STRB_W-1:0] strb
    );
        logic [DATA_W-1:0] res;
        res = cur;
        for (int i = 0; i < STRB_W; i++) begin
            if (strb[i]) res[8*i +: 8] = nxt[8*i +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/relu_axil_port.sv
module relu_axil_port
    import relu_accel_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [STRB_W-1:0] s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [STRB_W-1:0] wr_strb,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic              aw_held;
        logic [ADDR_W-1:0] awaddr;
        logic              w_held;
        logic [DATA_W-1:0] wdata;
        logic [STRB_W-1:0] wstrb;
        logic              bvalid;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } port_st_t;

    port_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        wr_en     = 1'b0;
        s_awready = !st_q.aw_held && !st_q.bvalid;
        s_wready  = !st_q.w_held && !st_q.bvalid;
        s_arready = !st_q.rvalid;

        if (st_q.aw_held && st_q.w_held) begin
            wr_en        = 1'b1;
            st_d.aw_held = 1'b0;
            st_d.w_held  = 1'b0;
            st_d.bvalid  = 1'b1;
        end
        if (s_awvalid && s_awready) begin
            st_d.aw_held = 1'b1;
            st_d.awaddr  = s_awaddr;
        end
        if (s_wvalid && s_wready) begin
            st_d.w_held = 1'b1;
            st_d.wdata  = s_wdata;
            st_d.wstrb  = s_wstrb;
        end
        if (st_q.bvalid && s_bready) st_d.bvalid = 1'b0;

        if (st_q.rvalid && s_rready) st_d.rvalid = 1'b0;
        if (s_arvalid && s_arready) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = rd_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_addr  = st_q.awaddr;
    assign wr_data  = st_q.wdata;
    assign wr_strb  = st_q.wstrb;
    assign rd_addr  = s_araddr;
    assign s_bvalid = st_q.bvalid;
    assign s_bresp  = RESP_OKAY;
    assign s_rvalid = st_q.rvalid;
    assign s_rdata  = st_q.rdata;
    assign s_rresp  = RESP_OKAY;

    AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid && !s_bready |=> s_bvalid) else $error("bvalid dropped"); // R8
    AST_RVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata)) else $error("rvalid/rdata unstable"); // R8
    AST_NO_WRITE_WHILE_BRESP: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid |-> !wr_en) else $error("write during response"); // R8

endmodule

// File: rtl/relu_core.sv
module relu_core
    import relu_accel_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [DATA_W-1:0] op_x,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic              busy,
    output logic              finish,
    output logic [DATA_W-1:0] result
);

    localparam int CNT_W = $clog2(LATENCY + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LATENCY - 1);

    typedef struct packed {
        logic              run;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] prod;
        logic [DATA_W-1:0] bias;
        logic              fin;
        logic [DATA_W-1:0] res;
    } core_st_t;

    core_st_t st_d, st_q;
    logic [DATA_W-1:0] sum;

    always_comb begin
        st_d     = st_q;
        st_d.fin = 1'b0;
        // Low half of a two's-complement product does not depend on signedness.
        sum      = st_q.prod + st_q.bias;
        if (launch) begin
            st_d.run  = 1'b1;
            st_d.cnt  = CNT_LAST;
            st_d.prod = op_a * op_x;
            st_d.bias = op_b;
        end else if (st_q.run) begin
            if (st_q.cnt == '0) begin
                st_d.run = 1'b0;
                st_d.fin = 1'b1;
                st_d.res = sum[DATA_W-1] ? '0 : sum;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = st_q.run || st_q.fin;
    assign finish = st_q.fin;
    assign result = st_q.res;

    AST_RESULT_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        finish |-> !result[DATA_W-1]) else $error("negative result"); // R4
    AST_LAUNCH_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !busy) else $error("launch while busy"); // R5
    AST_RUN_UNTIL_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.run) |-> finish) else $error("run ended without finish"); // R5

endmodule

// File: rtl/relu_regfile.sv
module relu_regfile
    import relu_accel_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [STRB_W-1:0] wr_strb,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              core_busy,
    input  logic              core_finish,
    input  logic [DATA_W-1:0] core_result,
    output logic              launch,
    output logic [DATA_W-1:0] op_x,
    output logic [DATA_W-1:0] op_a,
    output logic [DATA_W-1:0] op_b
);

    localparam int IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] IDX_CTRL = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_STAT = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_X    = IDX_W'(2);
    localparam logic [IDX_W-1:0] IDX_A    = IDX_W'(3);
    localparam logic [IDX_W-1:0] IDX_B    = IDX_W'(4);
    localparam logic [IDX_W-1:0] IDX_Y    = IDX_W'(5);

    typedef struct packed {
        logic              start;
        logic              done;
        logic [DATA_W-1:0] x;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic [DATA_W-1:0] y;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic             wr_ok, rd_ok;

    always_comb begin
        wr_idx = wr_addr[ADDR_W-1:2];
        rd_idx = rd_addr[ADDR_W-1:2];
        wr_ok  = wr_en && (wr_addr[1:0] == 2'b00);
        rd_ok  = (rd_addr[1:0] == 2'b00);

        st_d       = st_q;
        st_d.start = 1'b0;
        if (wr_ok) begin
            case (wr_idx)
                IDX_CTRL: if (wr_strb[0] && wr_data[0] && !st_q.start && !core_busy) begin
                    st_d.start = 1'b1;
                    st_d.done  = 1'b0;
                end
                IDX_X:   st_d.x = merge_lanes(st_q.x, wr_data, wr_strb);
                IDX_A:   st_d.a = merge_lanes(st_q.a, wr_data, wr_strb);
                IDX_B:   st_d.b = merge_lanes(st_q.b, wr_data, wr_strb);
                default: ;
            endcase
        end
        if (core_finish) begin
            st_d.y    = core_result;
            st_d.done = 1'b1;
        end

        rd_data = '0;
        if (rd_ok) begin
            case (rd_idx)
                IDX_CTRL: rd_data = {{(DATA_W-1){1'b0}}, st_q.start};
                IDX_STAT: rd_data = {{(DATA_W-1){1'b0}}, st_q.done};
                IDX_X:    rd_data = st_q.x;
                IDX_A:    rd_data = st_q.a;
                IDX_B:    rd_data = st_q.b;
                IDX_Y:    rd_data = st_q.y;
                default:  rd_data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign launch = st_q.start;
    assign op_x   = st_q.x;
    assign op_a   = st_q.a;
    assign op_b   = st_q.b;

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.start |=> !st_q.start) else $error("start not self-cleared"); // R7
    AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.start |=> !st_q.done) else $error("done set right after start"); // R2
    AST_DONE_FROM_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.done) |-> $past(core_finish)) else $error("done without finish"); // R5
    AST_BUSY_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        core_busy |=> !st_q.start) else $error("start accepted while busy"); // R5
    AST_Y_ONLY_ON_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        !core_finish |=> $stable(st_q.y)) else $error("y changed without finish"); // R6

endmodule

// File: rtl/affine_relu_accel.sv
module affine_relu_accel
    import relu_accel_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int LATENCY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [31:0]       s_wdata,
    input  logic [3:0]        s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [31:0]       s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready
);

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [STRB_W-1:0] wr_strb;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              launch, core_busy, core_finish;
    logic [DATA_W-1:0] op_x, op_a, op_b, core_result;

    relu_axil_port #(.ADDR_W(ADDR_W)) u_port (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    relu_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .core_busy(core_busy), .core_finish(core_finish), .core_result(core_result),
        .launch(launch), .op_x(op_x), .op_a(op_a), .op_b(op_b)
    );

    relu_core #(.LATENCY(LATENCY)) u_core (
        .clk(clk), .rst_n(rst_n),
        .launch(launch), .op_x(op_x), .op_a(op_a), .op_b(op_b),
        .busy(core_busy), .finish(core_finish), .result(core_result)
    );

endmodule

// File: tb/affine_relu_accel_bench.sv
module affine_relu_accel_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 6;
    localparam int LATENCY    = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] s_awaddr = '0;
    logic              s_awvalid = 1'b0;
    logic              s_awready;
    logic [31:0]       s_wdata = '0;
    logic [3:0]        s_wstrb = '0;
    logic              s_wvalid = 1'b0;
    logic              s_wready;
    logic [1:0]        s_bresp;
    logic              s_bvalid;
    logic              s_bready = 1'b0;
    logic [ADDR_W-1:0] s_araddr = '0;
    logic              s_arvalid = 1'b0;
    logic              s_arready;
    logic [31:0]       s_rdata;
    logic [1:0]        s_rresp;
    logic              s_rvalid;
    logic              s_rready = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    affine_relu_accel #(.ADDR_W(ADDR_W), .LATENCY(LATENCY)) u_affine_relu_accel (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
        .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
        .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
        .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] relu_ref(input logic [31:0] x, input logic [31:0] a,
                                              input logic [31:0] b);
        longint p;
        logic [63:0] pu;
        logic [31:0] s;
        p  = longint'($signed(x)) * longint'($signed(a));
        pu = p;
        s  = pu[31:0] + b;
        return s[31] ? 32'd0 : s;
    endfunction

    task automatic bus_write(input logic [ADDR_W-1:0] addr, input logic [31:0] data,
                             input logic [3:0] strb, output logic [1:0] resp);
        @(negedge clk);
        s_awaddr = addr; s_wdata = data; s_wstrb = strb;
        s_awvalid = 1'b1; s_wvalid = 1'b1;
        while (!(s_awready && s_wready)) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        s_awvalid = 1'b0; s_wvalid = 1'b0;
        while (!s_bvalid) @(negedge clk);
        resp = s_bresp;
        s_bready = 1'b1;
        @(negedge clk);
        s_bready = 1'b0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] addr, input logic [31:0] data);
        logic [1:0] resp;
        bus_write(addr, data, 4'hF, resp);
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] addr, output logic [31:0] data,
                            output logic [1:0] resp);
        @(negedge clk);
        s_araddr = addr; s_arvalid = 1'b1;
        while (!s_arready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        s_arvalid = 1'b0;
        while (!s_rvalid) @(negedge clk);
        data = s_rdata; resp = s_rresp;
        s_rready = 1'b1;
        @(negedge clk);
        s_rready = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] addr, output logic [31:0] data);
        logic [1:0] resp;
        bus_read(addr, data, resp);
    endtask

    task automatic wait_done(output logic [31:0] done_val);
        done_val = 32'd0;
        for (int n = 0; n < 40 && done_val != 32'd1; n++) rd(6'h04, done_val);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R8 watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v, dn, yv;
        logic [1:0]  resp;
        logic [31:0] vals [8];
        vals = '{32'd0, 32'd1, 32'hFFFF_FFFF, 32'd3, 32'hFFFF_FFFC, 32'd5,
                 32'h7FFF_FFFF, 32'h8000_0000};

        repeat (5) @(negedge clk);
        // R8: reset state at the ports and in every register
        check("R8 bvalid after reset", {31'd0, s_bvalid}, 32'd0);
        check("R8 rvalid after reset", {31'd0, s_rvalid}, 32'd0);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            rd(ADDR_W'(4*i), v);
            check($sformatf("R8 reset value offset %0h", 4*i), v, 32'd0);
        end

        // R7: control word reads 0 while idle
        rd(6'h00, v);
        check("R7 idle control word", v, 32'd0);

        // R3: operand read/write and byte strobes
        wr(6'h08, 32'h1122_3344);
        bus_write(6'h08, 32'hAABB_CCDD, 4'b0010, resp);
        rd(6'h08, v);
        check("R3 strobe lane 1 only", v, 32'h1122_CC44);
        bus_write(6'h08, 32'hAABB_CCDD, 4'b1001, resp);
        rd(6'h08, v);
        check("R3 strobe lanes 0 and 3", v, 32'hAA22_CCDD);
        wr(6'h0C, 32'hDEAD_BEEF);
        rd(6'h0C, v);
        check("R3 a readback", v, 32'hDEAD_BEEF);
        wr(6'h10, 32'h0BAD_F00D);
        rd(6'h10, v);
        check("R3 b readback", v, 32'h0BAD_F00D);

        // R2 / R4 / R5: the reference case
        wr(6'h08, 32'd5); wr(6'h0C, 32'd3); wr(6'h10, 32'hFFFF_FFFC);
        wr(6'h00, 32'd1);
        rd(6'h04, v);
        check("R2 done low after launch", v, 32'd0);
        wait_done(dn);
        check("R5 done after compute", dn, 32'd1);
        rd(6'h14, v);
        check("R4 y for x=5 a=3 b=-4", v, 32'd11);
        rd(6'h00, v);
        check("R7 control word after run", v, 32'd0);

        // R6: read-only and unmapped writes are accepted and dropped
        bus_write(6'h14, 32'h1234_5678, 4'hF, resp);
        check("R6 bresp on y write", {30'd0, resp}, 32'd0);
        bus_write(6'h04, 32'd0, 4'hF, resp);
        check("R6 bresp on done write", {30'd0, resp}, 32'd0);
        bus_write(6'h20, 32'h5555_5555, 4'hF, resp);
        check("R6 bresp on unmapped write", {30'd0, resp}, 32'd0);
        bus_write(6'h09, 32'h7777_7777, 4'hF, resp);
        rd(6'h14, v);
        check("R6 y unchanged", v, 32'd11);
        rd(6'h04, v);
        check("R6 done unchanged", v, 32'd1);
        rd(6'h08, v);
        check("R6 misaligned write dropped", v, 32'd5);
        bus_read(6'h20, v, resp);
        check("R6 unmapped read data", v, 32'd0);
        check("R6 unmapped read resp", {30'd0, resp}, 32'd0);
        rd(6'h18, v);
        check("R6 unmapped read 0x18", v, 32'd0);
        rd(6'h0A, v);
        check("R6 misaligned read", v, 32'd0);

        // R1: writing 0 (or only other bits) to the control word does nothing
        wr(6'h08, 32'd7);
        wr(6'h00, 32'd0);
        wr(6'h00, 32'd2);
        bus_write(6'h00, 32'd1, 4'b1110, resp);
        repeat (LATENCY + 6) @(negedge clk);
        rd(6'h04, v);
        check("R1 done unchanged after zero start", v, 32'd1);
        rd(6'h14, v);
        check("R1 y unchanged after zero start", v, 32'd11);

        // R5: a second start during the run is ignored
        wr(6'h08, 32'd2); wr(6'h0C, 32'd3); wr(6'h10, 32'd1);
        wr(6'h00, 32'd1);
        wr(6'h08, 32'd10);
        wr(6'h00, 32'd1);
        wait_done(dn);
        check("R5 done after first run", dn, 32'd1);
        repeat (LATENCY + 10) @(negedge clk);
        rd(6'h04, v);
        check("R5 done stays set, second start ignored", v, 32'd1);
        rd(6'h14, v);
        check("R5 y from first operands", v, 32'd7);

        // R4: sweep across signs and extremes
        foreach (vals[i]) foreach (vals[j]) foreach (vals[k]) begin
            wr(6'h08, vals[i]); wr(6'h0C, vals[j]); wr(6'h10, vals[k]);
            wr(6'h00, 32'd1);
            wait_done(dn);
            check("R2 done in sweep", dn, 32'd1);
            rd(6'h14, yv);
            check($sformatf("R4 sweep x=%h a=%h b=%h", vals[i], vals[j], vals[k]),
                  yv, relu_ref(vals[i], vals[j], vals[k]));
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule